// File: doc/BRIEF.md
# Multicycle Accumulator Processor with Synchronous Traps

This block is a small control processor that runs programs out of a single shared word-addressed memory. It works through each instruction as a sequence of states. First it reads the instruction word and advances the program counter. Then it classifies the opcode, and then it either finishes the instruction, performs one data access, or enters a trap. All arithmetic happens in one 16-bit accumulator. The instruction set covers loading a constant, adding a memory word, storing the accumulator, absolute jumps, conditional jumps, a service call, a return from a trap handler, and stopping.

Three events are synchronous traps: a service call, an undefined opcode, and a memory system that refuses a data access. For each trap the processor records a resume address and a cause code, then continues at a fixed handler address. The resume address differs by trap kind. A service call counts as complete, so it resumes after itself. A refused access or an undefined opcode counts as never executed, so it resumes at the same instruction, and a return from the handler runs that instruction again.

The controller has five named states. FETCH goes to DECODE after a word is read. FETCH goes to HALT when the program counter is out of range. DECODE goes back to FETCH for LDI, JMP, JZ and RETT. DECODE goes to MEM for ADDM and STA, to TRAP for a service call or an undefined opcode, and to HALT for HALT. MEM goes to FETCH when the access completes and to TRAP when it is refused. TRAP always goes to FETCH. HALT stays in HALT until reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, and on leaving reset, `pc_q`, `acc_q`, `epc_q` and `cause_q` are all zero and `halted` is low.
- R2: An instruction word carries its opcode in bits 15:12 and a 12-bit operand in bits 11:0. Opcode 0x0 (LDI) loads the zero-extended operand into the accumulator.
- R3: Opcode 0x1 (ADDM) adds the memory word at the operand address to the accumulator, modulo 2^16.
- R4: Opcode 0x2 (STA) writes the accumulator to the operand address with exactly one write strobe, and it never asserts the read and write strobes together.
- R5: Opcode 0x3 (JMP) makes the next fetch come from the operand address.
- R6: Opcode 0x4 (JZ) jumps to the operand address only when the accumulator is zero. Otherwise execution continues with the next word.
- R7: Opcode 0x5 (SYSCALL) is a trap. It sets `epc_q` to the address after itself and `cause_q` to 1, and execution continues at address 0x100.
- R8: If `mem_fault` is high during the data access of ADDM or STA, the instruction has no effect on the accumulator or memory. `epc_q` takes the instruction's own address, `cause_q` becomes 3, and execution continues at 0x100.
- R9: Opcodes 0x7 to 0xE are undefined. Each one traps with `cause_q` = 2 and `epc_q` set to its own address.
- R10: Opcode 0x6 (RETT) loads the program counter from `epc_q`. After a data fault, this re-runs the faulting instruction.
- R11: Opcode 0xF (HALT) raises `halted`. After that no memory strobe is issued until reset, and `pc_q` holds the address after the HALT word.
- R12: A fetch from an address of 0xC00 or above is not performed. The processor halts instead, and `pc_q` keeps that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Word address for the fetch or data access |
| mem_rd | output | 1 | Read strobe; the word is taken from `mem_rdata` in the same cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` |
| mem_wdata | output | 16 | Store data (accumulator) |
| mem_rdata | input | 16 | Read data, valid in the cycle of the strobe |
| mem_fault | input | 1 | Memory system refuses the current data access |
| halted | output | 1 | Processor has stopped |
| acc_q | output | 16 | Accumulator |
| pc_q | output | 12 | Program counter |
| epc_q | output | 12 | Saved resume address of the last trap |
| cause_q | output | 2 | Last trap cause: 1 service call, 2 undefined opcode, 3 data fault |

## Verification
The properties assume that the memory answers a read in the same cycle and that `mem_fault` depends only on the address. They also assume `mem_fault` is only meaningful during a data access, so a raised fault during an instruction read is ignored. To stay inside these assumptions, the bench keeps all data words at 0x800 and above, where no instruction is ever fetched. It derives the refusal from an address match alone, so the fault never depends on the write strobe it gates. Sweeps over constants, addend pairs that wrap, zero and non-zero branch conditions, and every undefined opcode are compared with values the bench computes arithmetically.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam logic [3:0] OPC_LDI  = 4'h0;
    localparam logic [3:0] OPC_ADDM = 4'h1;
    localparam logic [3:0] OPC_STA  = 4'h2;
    localparam logic [3:0] OPC_JMP  = 4'h3;
    localparam logic [3:0] OPC_JZ   = 4'h4;
    localparam logic [3:0] OPC_SYSC = 4'h5;
    localparam logic [3:0] OPC_RETT = 4'h6;
    localparam logic [3:0] OPC_HALT = 4'hF;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MEM,
        ST_TRAP,
        ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        IC_LDI,
        IC_ADDM,
        IC_STA,
        IC_JMP,
        IC_JZ,
        IC_SYSC,
        IC_RETT,
        IC_HALT,
        IC_ILL
    } iclass_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_SYSC = 2'd1,
        CAUSE_ILL  = 2'd2,
        CAUSE_MEMF = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        PC_HOLD,
        PC_INC,
        PC_OPND,
        PC_EPC,
        PC_VEC
    } pc_sel_e;

    typedef enum logic [1:0] {
        ACC_HOLD,
        ACC_IMM,
        ACC_SUM
    } acc_sel_e;

    typedef struct packed {
        logic     ir_ld;
        pc_sel_e  pc_sel;
        acc_sel_e acc_sel;
        logic     trap_ld;
        logic     epc_next;
        cause_e   cause;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{
        ir_ld:    1'b0,
        pc_sel:   PC_HOLD,
        acc_sel:  ACC_HOLD,
        trap_ld:  1'b0,
        epc_next: 1'b0,
        cause:    CAUSE_NONE
    };

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic [OPC_W-1:0] opcode,
    output iclass_e          iclass
);

    always_comb begin
        unique case (opcode)
            OPC_LDI:  iclass = IC_LDI;
            OPC_ADDM: iclass = IC_ADDM;
            OPC_STA:  iclass = IC_STA;
            OPC_JMP:  iclass = IC_JMP;
            OPC_JZ:   iclass = IC_JZ;
            OPC_SYSC: iclass = IC_SYSC;
            OPC_RETT: iclass = IC_RETT;
            OPC_HALT: iclass = IC_HALT;
            default:  iclass = IC_ILL;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int               ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] FETCH_LIMIT = 12'hC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  iclass_e           iclass,
    input  logic              acc_zero,
    input  logic [ADDR_W-1:0] pc,
    input  logic              mem_fault,
    output state_e            state,
    output ctl_t              ctl,
    output logic              addr_opnd,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted
);

    state_e state_r;
    state_e state_nx;
    logic   pc_beyond;

    assign pc_beyond = (pc >= FETCH_LIMIT);
    assign state     = state_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_r <= ST_FETCH;
        end else begin
            state_r <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            ST_FETCH: begin
                state_nx = pc_beyond ? ST_HALT : ST_DECODE;
            end
            ST_DECODE: begin
                unique case (iclass)
                    IC_ADDM, IC_STA: state_nx = ST_MEM;
                    IC_SYSC, IC_ILL: state_nx = ST_TRAP;
                    IC_HALT:         state_nx = ST_HALT;
                    default:         state_nx = ST_FETCH;
                endcase
            end
            ST_MEM: begin
                state_nx = mem_fault ? ST_TRAP : ST_FETCH;
            end
            ST_TRAP: begin
                state_nx = ST_FETCH;
            end
            ST_HALT: begin
                state_nx = ST_HALT;
            end
            default: begin
                state_nx = ST_HALT;
            end
        endcase
    end

    // outputs
    always_comb begin
        ctl       = CTL_IDLE;
        addr_opnd = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        halted    = 1'b0;
        unique case (state_r)
            ST_FETCH: begin
                if (!pc_beyond) begin
                    mem_rd     = 1'b1;
                    ctl.ir_ld  = 1'b1;
                    ctl.pc_sel = PC_INC;
                end
            end
            ST_DECODE: begin
                unique case (iclass)
                    IC_LDI:  ctl.acc_sel = ACC_IMM;
                    IC_JMP:  ctl.pc_sel  = PC_OPND;
                    IC_JZ:   ctl.pc_sel  = acc_zero ? PC_OPND : PC_HOLD;
                    IC_RETT: ctl.pc_sel  = PC_EPC;
                    IC_SYSC: begin
                        ctl.trap_ld  = 1'b1;
                        ctl.epc_next = 1'b1;
                        ctl.cause    = CAUSE_SYSC;
                    end
                    IC_ILL: begin
                        ctl.trap_ld  = 1'b1;
                        ctl.epc_next = 1'b0;
                        ctl.cause    = CAUSE_ILL;
                    end
                    default: ;
                endcase
            end
            ST_MEM: begin
                addr_opnd = 1'b1;
                if (iclass == IC_ADDM) begin
                    mem_rd = 1'b1;
                end else begin
                    mem_wr = !mem_fault;
                end
                if (mem_fault) begin
                    ctl.trap_ld  = 1'b1;
                    ctl.epc_next = 1'b0;
                    ctl.cause    = CAUSE_MEMF;
                end else if (iclass == IC_ADDM) begin
                    ctl.acc_sel = ACC_SUM;
                end
            end
            ST_TRAP: begin
                ctl.pc_sel = PC_VEC;
            end
            ST_HALT: begin
                halted = 1'b1;
            end
            default: begin
                halted = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
    import acc_cpu_pkg::*;
#(
    parameter int               ADDR_W       = 12,
    parameter int               OPC_W        = 4,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  ctl_t                      ctl,
    input  logic                      addr_opnd,
    input  logic [OPC_W+ADDR_W-1:0]   mem_rdata,
    output logic [OPC_W-1:0]          opcode,
    output logic                      acc_zero,
    output logic [ADDR_W-1:0]         pc,
    output logic [OPC_W+ADDR_W-1:0]   acc,
    output logic [ADDR_W-1:0]         epc,
    output cause_e                    cause,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [OPC_W+ADDR_W-1:0]   mem_wdata
);

    localparam int DATA_W = OPC_W + ADDR_W;

    logic [ADDR_W-1:0] pc_r;
    logic [ADDR_W-1:0] ipc_r;
    logic [DATA_W-1:0] ir_r;
    logic [DATA_W-1:0] acc_r;
    logic [ADDR_W-1:0] epc_r;
    cause_e            cause_r;
    logic [ADDR_W-1:0] operand;
    logic [DATA_W-1:0] operand_ext;
    logic [ADDR_W-1:0] pc_nx;
    logic [DATA_W-1:0] acc_nx;

    assign operand     = ir_r[ADDR_W-1:0];
    assign operand_ext = {{OPC_W{1'b0}}, operand};
    assign opcode      = ir_r[DATA_W-1:ADDR_W];
    assign acc_zero    = (acc_r == '0);
    assign mem_addr    = addr_opnd ? operand : pc_r;
    assign mem_wdata   = acc_r;

    always_comb begin
        unique case (ctl.pc_sel)
            PC_INC:  pc_nx = pc_r + 1'b1;
            PC_OPND: pc_nx = operand;
            PC_EPC:  pc_nx = epc_r;
            PC_VEC:  pc_nx = HANDLER_ADDR;
            default: pc_nx = pc_r;
        endcase
    end

    always_comb begin
        unique case (ctl.acc_sel)
            ACC_IMM: acc_nx = operand_ext;
            ACC_SUM: acc_nx = acc_r + mem_rdata;
            default: acc_nx = acc_r;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_r    <= '0;
            ipc_r   <= '0;
            ir_r    <= '0;
            acc_r   <= '0;
            epc_r   <= '0;
            cause_r <= CAUSE_NONE;
        end else begin
            pc_r  <= pc_nx;
            acc_r <= acc_nx;
            if (ctl.ir_ld) begin
                ir_r  <= mem_rdata;
                ipc_r <= pc_r;
            end
            if (ctl.trap_ld) begin
                epc_r   <= ctl.epc_next ? pc_r : ipc_r;
                cause_r <= ctl.cause;
            end
        end
    end

    assign pc    = pc_r;
    assign acc   = acc_r;
    assign epc   = epc_r;
    assign cause = cause_r;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int               ADDR_W       = 12,
    parameter int               OPC_W        = 4,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100,
    parameter logic [ADDR_W-1:0] FETCH_LIMIT  = 12'hC00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [OPC_W+ADDR_W-1:0] mem_wdata,
    input  logic [OPC_W+ADDR_W-1:0] mem_rdata,
    input  logic                    mem_fault,
    output logic                    halted,
    output logic [OPC_W+ADDR_W-1:0] acc_q,
    output logic [ADDR_W-1:0]       pc_q,
    output logic [ADDR_W-1:0]       epc_q,
    output logic [1:0]              cause_q
);

    localparam int DATA_W = OPC_W + ADDR_W;

    logic [OPC_W-1:0]  opcode;
    iclass_e           iclass;
    logic              acc_zero;
    state_e            fsm_state;
    ctl_t              ctl;
    logic              addr_opnd;
    cause_e            cause;
    logic [DATA_W-1:0] acc;

    acc_cpu_decode #(
        .OPC_W (OPC_W)
    ) u_decode (
        .opcode (opcode),
        .iclass (iclass)
    );

    acc_cpu_ctrl #(
        .ADDR_W      (ADDR_W),
        .FETCH_LIMIT (FETCH_LIMIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .iclass    (iclass),
        .acc_zero  (acc_zero),
        .pc        (pc_q),
        .mem_fault (mem_fault),
        .state     (fsm_state),
        .ctl       (ctl),
        .addr_opnd (addr_opnd),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted)
    );

    acc_cpu_dpath #(
        .ADDR_W       (ADDR_W),
        .OPC_W        (OPC_W),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .addr_opnd (addr_opnd),
        .mem_rdata (mem_rdata),
        .opcode    (opcode),
        .acc_zero  (acc_zero),
        .pc        (pc_q),
        .acc       (acc),
        .epc       (epc_q),
        .cause     (cause),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign acc_q   = acc;
    assign cause_q = cause;

endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker
    import acc_cpu_pkg::*;
#(
    parameter int               ADDR_W       = 12,
    parameter int               DATA_W       = 16,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100,
    parameter logic [ADDR_W-1:0] FETCH_LIMIT  = 12'hC00
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            st,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_fault,
    input logic              halted,
    input logic [DATA_W-1:0] acc_q,
    input logic [ADDR_W-1:0] pc_q
);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_store_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(acc_q));

    p_trap_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRAP) |=> (pc_q == HANDLER_ADDR));

    p_fault_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_fault);

    p_fault_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MEM && mem_fault) |=> $stable(acc_q));

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    p_fetch_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH && mem_rd) |-> (pc_q < FETCH_LIMIT));

endmodule

bind acc_cpu acc_cpu_checker #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (OPC_W + ADDR_W),
    .HANDLER_ADDR (HANDLER_ADDR),
    .FETCH_LIMIT  (FETCH_LIMIT)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (fsm_state),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_fault (mem_fault),
    .halted    (halted),
    .acc_q     (acc_q),
    .pc_q      (pc_q)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int WORDS = 1 << AW;
    localparam logic [AW-1:0] DATA_A = 12'h800;
    localparam logic [AW-1:0] DATA_B = 12'h801;
    localparam logic [AW-1:0] VEC = 12'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_fault;
    logic          halted;
    logic [DW-1:0] acc_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] epc_q;
    logic [1:0]    cause_q;

    logic [DW-1:0] mem [0:WORDS-1];
    logic          clr = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          fault_req = 1'b0;
    logic          fault_once = 1'b0;
    logic          fault_spent;
    int            wr_cnt;
    int            fault_hits;
    int            post_halt_acc;
    int            high_rd;
    int            n_chk = 0;
    int            n_err = 0;
    int            cycles = 0;

    acc_cpu i_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_fault (mem_fault),
        .halted    (halted),
        .acc_q     (acc_q),
        .pc_q      (pc_q),
        .epc_q     (epc_q),
        .cause_q   (cause_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    assign mem_fault = fault_req && !(fault_once && fault_spent) && (mem_addr == DATA_A || mem_addr == DATA_B);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (clr) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hF000;
            wr_cnt <= 0;
            fault_hits <= 0;
            post_halt_acc <= 0;
            high_rd <= 0;
            fault_spent <= 1'b0;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (rst_n) begin
            if (mem_wr && !mem_fault) mem[mem_addr] <= mem_wdata;
            if (mem_wr) wr_cnt <= wr_cnt + 1;
            if (mem_fault && (mem_rd || mem_wr)) begin
                fault_hits <= fault_hits + 1;
                fault_spent <= 1'b1;
            end
            if (halted && (mem_rd || mem_wr)) post_halt_acc <= post_halt_acc + 1;
            if (mem_rd && mem_addr >= 12'hC00) high_rd <= high_rd + 1;
        end
    end

    function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] arg);
        return {op, arg};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0;
        fault_req = 1'b0;
        fault_once = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ld_en = 1'b1;
        ld_addr = a;
        ld_data = d;
    endtask

    task automatic run_prog();
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 400 && !halted; c++) @(negedge clk);
        chk("R11", "run reaches halt", {31'd0, halted}, 32'd1);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        begin_prog();
        @(negedge clk);
        chk("R1", "pc in reset", pc_q, 0);
        chk("R1", "acc in reset", acc_q, 0);
        chk("R1", "epc in reset", epc_q, 0);
        chk("R1", "cause in reset", cause_q, 0);
        chk("R1", "halted in reset", halted, 0);

        // R2: LDI sweep over constants
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] k;
            k = AW'((i * 12'h2F7 + (i == 7 ? 12'hFFF : 12'h0)) & 12'hFFF);
            begin_prog();
            poke(0, ins(4'h0, k));
            poke(1, ins(4'hF, 0));
            run_prog();
            chk("R2", "LDI constant", acc_q, {4'h0, k});
            chk("R11", "pc after HALT", pc_q, 2);
        end

        // R3: ADDM sweep including wrap
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] x;
            logic [DW-1:0] y;
            logic [DW-1:0] e;
            x = AW'((i * 12'h1F3) & 12'hFFF);
            y = DW'(i * 16'h2345 + 16'hF000);
            e = DW'({4'h0, x} + y);
            begin_prog();
            poke(0, ins(4'h0, x));
            poke(1, ins(4'h1, DATA_A));
            poke(2, ins(4'hF, 0));
            poke(DATA_A, y);
            run_prog();
            chk("R3", "ADDM sum", acc_q, e);
        end

        // R4: STA writes accumulator once
        begin_prog();
        poke(0, ins(4'h0, 12'h123));
        poke(1, ins(4'h1, DATA_A));
        poke(2, ins(4'h2, DATA_B));
        poke(3, ins(4'hF, 0));
        poke(DATA_A, 16'hA000);
        run_prog();
        chk("R4", "stored word", mem[DATA_B], 16'hA123);
        chk("R4", "write strobes", wr_cnt, 1);

        // R5: JMP
        begin_prog();
        poke(0, ins(4'h3, 12'h020));
        poke(1, ins(4'h0, 12'h001));
        poke(2, ins(4'hF, 0));
        poke(12'h020, ins(4'h0, 12'h007));
        poke(12'h021, ins(4'hF, 0));
        run_prog();
        chk("R5", "jump target ran", acc_q, 7);
        chk("R5", "pc after jumped HALT", pc_q, 12'h022);

        // R6: JZ sweep, plus a zero reached by wrap
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] v;
            logic [DW-1:0] e;
            v = AW'(i * 12'h333);
            begin_prog();
            if (i == 5) begin
                poke(0, ins(4'h0, 12'h001));
                poke(DATA_A, 16'hFFFF);
                v = 0;
            end else begin
                poke(0, ins(4'h0, v));
            end
            poke(1, (i == 5) ? ins(4'h1, DATA_A) : ins(4'h0, v));
            poke(2, ins(4'h4, 12'h030));
            poke(3, ins(4'h0, 12'h0AA));
            poke(4, ins(4'hF, 0));
            poke(12'h030, ins(4'h0, 12'h055));
            poke(12'h031, ins(4'hF, 0));
            run_prog();
            e = (v == 0) ? 16'h0055 : 16'h00AA;
            chk("R6", "JZ path", acc_q, e);
        end

        // R7: SYSCALL saves next address and vectors
        begin_prog();
        poke(0, ins(4'h0, 12'h003));
        poke(1, ins(4'h5, 0));
        poke(2, ins(4'h0, 12'h0EE));
        poke(VEC, ins(4'hF, 0));
        run_prog();
        chk("R7", "epc after call", epc_q, 2);
        chk("R7", "cause after call", cause_q, 1);
        chk("R7", "handler reached", pc_q, VEC + 1);
        chk("R7", "acc kept", acc_q, 3);

        // R10: return from service call resumes after it
        begin_prog();
        poke(0, ins(4'h0, 12'h003));
        poke(1, ins(4'h5, 0));
        poke(2, ins(4'h1, DATA_A));
        poke(3, ins(4'hF, 0));
        poke(DATA_A, 16'h000A);
        poke(VEC, ins(4'h6, 0));
        run_prog();
        chk("R10", "resume after call", acc_q, 13);
        chk("R10", "pc at end", pc_q, 4);

        // R8: refused ADDM
        begin_prog();
        poke(0, ins(4'h0, 12'h004));
        poke(1, ins(4'h1, DATA_A));
        poke(2, ins(4'hF, 0));
        poke(DATA_A, 16'h0005);
        poke(VEC, ins(4'hF, 0));
        fault_req = 1'b1;
        run_prog();
        chk("R8", "acc untouched by faulted ADDM", acc_q, 4);
        chk("R8", "epc is faulting instr", epc_q, 1);
        chk("R8", "cause data fault", cause_q, 3);
        chk("R8", "handler reached", pc_q, VEC + 1);

        // R8: refused STA leaves memory alone
        begin_prog();
        poke(0, ins(4'h0, 12'h004));
        poke(1, ins(4'h2, DATA_B));
        poke(2, ins(4'hF, 0));
        poke(DATA_B, 16'hBEEF);
        poke(VEC, ins(4'hF, 0));
        fault_req = 1'b1;
        run_prog();
        chk("R8", "memory untouched by faulted STA", mem[DATA_B], 16'hBEEF);
        chk("R8", "no write strobe on fault", wr_cnt, 0);
        chk("R8", "epc of faulted STA", epc_q, 1);

        // R10: fault once then re-execute
        begin_prog();
        poke(0, ins(4'h0, 12'h004));
        poke(1, ins(4'h1, DATA_A));
        poke(2, ins(4'hF, 0));
        poke(DATA_A, 16'h0005);
        poke(VEC, ins(4'h6, 0));
        fault_req = 1'b1;
        fault_once = 1'b1;
        run_prog();
        chk("R10", "re-executed ADDM", acc_q, 9);
        chk("R10", "fault seen once", fault_hits, 1);
        chk("R10", "cause kept", cause_q, 3);
        chk("R10", "pc at end", pc_q, 3);

        // R9: every undefined opcode
        for (int op = 7; op <= 14; op++) begin
            begin_prog();
            poke(0, ins(4'h0, 12'h001));
            poke(1, ins(4'(op), 12'h0AB));
            poke(2, ins(4'h0, 12'h0EE));
            poke(VEC, ins(4'hF, 0));
            run_prog();
            chk("R9", "undefined opcode cause", cause_q, 2);
            chk("R9", "undefined opcode epc", epc_q, 1);
            chk("R9", "acc kept", acc_q, 1);
        end

        // R12: fetch beyond range
        begin_prog();
        poke(0, ins(4'h3, 12'hC00));
        run_prog();
        chk("R12", "pc parked at limit", pc_q, 12'hC00);
        chk("R12", "no read beyond limit", high_rd, 0);

        // R11: no accesses after halt
        repeat (20) @(negedge clk);
        chk("R11", "quiet after halt", post_halt_acc, 0);
        chk("R11", "still halted", halted, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule